// File: doc/BRIEF.md
# Zero-Cross Synchronized Thyristor Firing Pulse Generator

This block drives the gate of a back-to-back thyristor pair (or a TRIAC) that sets the current through a compensating reactor. A digital sync pulse marks each zero crossing of the supply voltage. Its rising edge starts a delay timer. When the programmed firing angle has elapsed, the block issues one gate pulse of fixed width. The firing angle is given as a delay in microseconds. A supply period of 20 ms at 50 Hz makes one 0.9° step equal to 50 µs. After reset the delay is 3333 µs, which is 60°.

An angle controller writes a new delay with a load strobe. The value waits in a pending register and moves to the active register only on the next recognized sync rising edge. A firing that is already being timed therefore keeps the delay it started with. The timer counts a 1 µs tick-enable input, so the block makes no assumption about the system clock frequency. The raw sync level passes through a two-stage synchronizer before edge detection.

Top module: `pfc_fire_gen`

## Requirements
- R1: While `rst` is high, and after it falls until the first sync rising edge is recognized, `gate_out` is low. A reset in the middle of a gate pulse forces `gate_out` low at the next clock edge.
- R2: If no load is made after reset, the first firing uses a delay of 3333 ticks (60° at 50 Hz).
- R3: A low-to-high transition of `sync_in` is recognized 3 clock edges after it is first sampled high (two synchronizer stages plus one edge register). With a tick on every clock, `gate_out` rises exactly 3 + A clock edges after `sync_in` is first sampled high, where A is the active delay (unsigned, in µs ticks).
- R4: `gate_out` stays high for exactly `PULSE_US` ticks (default 100) per firing.
- R5: A value loaded through `alpha_load`/`alpha_us` does not move a firing that is already being timed. It becomes the active delay at the next recognized sync rising edge.
- R6: A sync rising edge recognized while a delay is still running restarts the delay from zero with the delay latched at that edge. The interrupted cycle emits no pulse.
- R7: A sync rising edge recognized while the gate pulse is high does not shorten, stretch or restart the pulse, and no further pulse follows from it.
- R8: Exactly one gate pulse is produced per recognized rising edge. A long high sync level and falling sync edges do not trigger pulses.
- R9: The delay and pulse counters advance only on clocks where `tick_us` is high. With a tick on every 4th clock, the pulse lasts 4·`PULSE_US` clocks.
- R10: An active delay of 0 is treated as 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-clock enable, once per microsecond |
| sync_in | input | 1 | Zero-crossing sync level, asynchronous |
| alpha_load | input | 1 | Strobe that writes `alpha_us` into the pending register |
| alpha_us | input | ALPHA_W (16) | Firing delay in microseconds |
| gate_out | output | 1 | Gate trigger pulse for the thyristor driver |

## Verification
The bench targets the following corner cases, each tied to a specific fault:
- A load in the middle of a delay. A design that used the live delay value would fire early or late in that cycle.
- A second sync edge during the delay. A design that failed to restart would emit a stray pulse from the aborted cycle.
- A second sync edge during the gate pulse. A design that restarted or truncated would shorten the pulse or fire a second time.
- A sync level held high for a long time. Level-sensitive triggering would fire repeatedly.
- Counting ticks rather than clocks, checked with a sparse tick.
- A delay of zero. A design without the clamp would wrap the counter and wait 65536 ticks.

// File: rtl/pfc_fire_pkg.sv
`timescale 1ns/1ps
package pfc_fire_pkg;

    // 0.9 degree at 50 Hz expressed in microseconds
    localparam int unsigned US_PER_STEP = 50;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_DELAY = 2'd1,
        FS_PULSE = 2'd2
    } fire_state_e;

    // a zero delay is raised to one tick so the counter never wraps
    function automatic int unsigned at_least_one(input int unsigned v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int unsigned steps_to_us(input int unsigned steps);
        return steps * US_PER_STEP;
    endfunction

endpackage

// File: rtl/pfc_sync_edge.sv
`timescale 1ns/1ps
module pfc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic rise
);
    logic stage_q [STAGES];
    logic prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= 1'b0;
                else     stage_q[0] <= sync_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= 1'b0;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= stage_q[STAGES-1];
    end

    assign rise = stage_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pfc_angle_latch.sv
`timescale 1ns/1ps
module pfc_angle_latch #(
    parameter int          W      = 16,
    parameter int unsigned RST_US = 3333
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    input  logic         take,
    output logic [W-1:0] active
);
    localparam logic [W-1:0] RST_VAL = W'(RST_US);

    logic [W-1:0] pend_q;
    logic [W-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst)       pend_q <= RST_VAL;
        else if (load) pend_q <= value;
    end

    // the active angle only changes at a cycle boundary
    always_ff @(posedge clk) begin
        if (rst)       act_q <= RST_VAL;
        else if (take) act_q <= pend_q;
    end

    assign active = act_q;

endmodule

// File: rtl/pfc_fire_timer.sv
`timescale 1ns/1ps
module pfc_fire_timer
    import pfc_fire_pkg::*;
#(
    parameter int          W        = 16,
    parameter int unsigned PULSE_US = 100
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         start,
    input  logic [W-1:0] delay,
    output logic         gate
);
    localparam int PW = $clog2(PULSE_US + 1);
    localparam int CW = (W > PW) ? W : PW;
    localparam logic [CW:0] PULSE_LIM = (CW+1)'(PULSE_US);

    typedef struct packed {
        fire_state_e     st;
        logic [CW-1:0]   cnt;
    } tmr_t;

    tmr_t        cur_q;
    tmr_t        nxt;
    logic [CW:0] cnt_inc;
    logic [CW:0] dly_lim;

    assign dly_lim = (CW+1)'(at_least_one(32'(delay)));

    always_comb begin
        nxt     = cur_q;
        cnt_inc = {1'b0, cur_q.cnt} + {{CW{1'b0}}, 1'b1};
        if (start && cur_q.st != FS_PULSE) begin
            nxt.st  = FS_DELAY;
            nxt.cnt = '0;
        end else if (tick) begin
            case (cur_q.st)
                FS_DELAY: begin
                    if (cnt_inc >= dly_lim) begin
                        nxt.st  = FS_PULSE;
                        nxt.cnt = '0;
                    end else begin
                        nxt.cnt = cnt_inc[CW-1:0];
                    end
                end
                FS_PULSE: begin
                    if (cnt_inc >= PULSE_LIM) begin
                        nxt.st  = FS_IDLE;
                        nxt.cnt = '0;
                    end else begin
                        nxt.cnt = cnt_inc[CW-1:0];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.st  <= FS_IDLE;
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt;
        end
    end

    assign gate = (cur_q.st == FS_PULSE);

endmodule

// File: rtl/pfc_fire_gen.sv
`timescale 1ns/1ps
module pfc_fire_gen #(
    parameter int          ALPHA_W     = 16,
    parameter int unsigned ALPHA_RST_US = 3333,
    parameter int unsigned PULSE_US    = 100,
    parameter int          SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_us,
    input  logic               sync_in,
    input  logic               alpha_load,
    input  logic [ALPHA_W-1:0] alpha_us,
    output logic               gate_out
);
    logic               sync_rise;
    logic [ALPHA_W-1:0] alpha_act;

    pfc_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .rise    (sync_rise)
    );

    pfc_angle_latch #(
        .W      (ALPHA_W),
        .RST_US (ALPHA_RST_US)
    ) u_angle (
        .clk    (clk),
        .rst    (rst),
        .load   (alpha_load),
        .value  (alpha_us),
        .take   (sync_rise),
        .active (alpha_act)
    );

    pfc_fire_timer #(
        .W        (ALPHA_W),
        .PULSE_US (PULSE_US)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_us),
        .start (sync_rise),
        .delay (alpha_act),
        .gate  (gate_out)
    );

endmodule

// File: rtl/pfc_fire_gen_chk.sv
`timescale 1ns/1ps
module pfc_fire_gen_chk #(
    parameter int unsigned PULSE_US = 100
) (
    input logic clk,
    input logic rst,
    input logic tick_us,
    input logic sync_rise,
    input logic gate_out
);
    localparam int HW = $clog2(PULSE_US + 2);

    logic [HW-1:0] hi_ticks;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst || !gate_out) hi_ticks <= '0;
        else if (tick_us)     hi_ticks <= hi_ticks + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)            armed <= 1'b0;
        else if (sync_rise) armed <= 1'b1;
        else if (gate_out)  armed <= 1'b0;
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !gate_out); // R1

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        hi_ticks <= HW'(PULSE_US)); // R4

    AST_FULL_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_out) |-> hi_ticks == HW'(PULSE_US)); // R7

    AST_FIRE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_out) |-> armed); // R8

    AST_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
        !tick_us |=> $stable(gate_out)); // R9

endmodule

bind pfc_fire_gen pfc_fire_gen_chk #(
    .PULSE_US (PULSE_US)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_us   (tick_us),
    .sync_rise (sync_rise),
    .gate_out  (gate_out)
);

// File: tb/sim_pfc_fire_gen.sv
`timescale 1ns/1ps
module sim_pfc_fire_gen;
    localparam int P   = 100;
    localparam int LAT = 3;
    localparam int VEC_N = 7;
    localparam int VEC_A [VEC_N] = '{3380, 3280, 200, 57, 1, 0, 777};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_us = 1'b0;
    logic        sync_in = 1'b0;
    logic        alpha_load = 1'b0;
    logic [15:0] alpha_us = '0;
    logic        gate_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tick_div = 1;
    int phase = 0;
    bit done = 0;
    logic gate_q = 1'b0;
    int rise_cyc = 0;
    int fall_cyc = 0;
    int rise_cnt = 0;

    pfc_fire_gen u0 (
        .clk        (clk),
        .rst        (rst),
        .tick_us    (tick_us),
        .sync_in    (sync_in),
        .alpha_load (alpha_load),
        .alpha_us   (alpha_us),
        .gate_out   (gate_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (tick_div <= 1) tick_us = 1'b1;
        else begin
            tick_us = (phase == 0);
            phase = (phase + 1) % tick_div;
        end
    end

    always @(negedge clk) begin
        if (gate_out && !gate_q) begin
            rise_cyc = cyc;
            rise_cnt++;
        end
        if (!gate_out && gate_q) fall_cyc = cyc;
        gate_q = gate_out;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input int a);
        @(negedge clk);
        alpha_us = 16'(a);
        alpha_load = 1'b1;
        @(negedge clk);
        alpha_load = 1'b0;
    endtask

    task automatic sync_pulse(output int c0, input int hold);
        @(negedge clk);
        sync_in = 1'b1;
        c0 = cyc;
        repeat (hold) @(negedge clk);
        sync_in = 1'b0;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int c0, c1, n0, d;
        // R1: reset state
        idle(10);
        chk(gate_out == 1'b0, "R1", "gate in reset", gate_out, 0);
        rst = 1'b0;
        idle(50);
        chk(rise_cnt == 0 && gate_out == 1'b0, "R1", "pulses before sync", rise_cnt, 0);

        // R2: default angle 3333 us
        sync_pulse(c0, 10);
        idle(LAT + 3333 + P + 10);
        chk(rise_cyc - c0 == LAT + 3333, "R2", "default delay", rise_cyc - c0, LAT + 3333);
        chk(fall_cyc - rise_cyc == P, "R4", "default width", fall_cyc - rise_cyc, P);

        // table of delays: R3, R4, R8, R10
        for (int i = 0; i < VEC_N; i++) begin
            int a, e;
            a = VEC_A[i];
            e = LAT + ((a == 0) ? 1 : a);
            load(a);
            idle(5);
            n0 = rise_cnt;
            sync_pulse(c0, 10);
            idle(e + P + 10);
            chk(rise_cyc - c0 == e, (a == 0) ? "R10" : "R3", "delay", rise_cyc - c0, e);
            chk(fall_cyc - rise_cyc == P, "R4", "width", fall_cyc - rise_cyc, P);
            chk(rise_cnt == n0 + 1, "R8", "pulses per edge", rise_cnt - n0, 1);
        end

        // R5: load during a running delay
        load(400);
        idle(3);
        sync_pulse(c0, 10);
        idle(100);
        load(150);
        idle(400 + P + 20);
        chk(rise_cyc - c0 == LAT + 400, "R5", "current cycle kept", rise_cyc - c0, LAT + 400);
        sync_pulse(c1, 10);
        idle(150 + P + 10);
        chk(rise_cyc - c1 == LAT + 150, "R5", "next cycle uses load", rise_cyc - c1, LAT + 150);

        // R6: new sync edge during delay restarts
        load(300);
        idle(3);
        n0 = rise_cnt;
        sync_pulse(c0, 10);
        idle(90);
        load(250);
        idle(5);
        sync_pulse(c1, 10);
        idle(250 + P + 20);
        chk(rise_cnt == n0 + 1, "R6", "aborted cycle silent", rise_cnt - n0, 1);
        chk(rise_cyc - c1 == LAT + 250, "R6", "restart delay", rise_cyc - c1, LAT + 250);

        // R7: sync edge during the pulse
        load(50);
        idle(3);
        n0 = rise_cnt;
        sync_pulse(c0, 10);
        idle(60);
        sync_pulse(c1, 10);
        idle(400);
        chk(rise_cyc - c0 == LAT + 50, "R7", "first delay", rise_cyc - c0, LAT + 50);
        chk(fall_cyc - rise_cyc == P, "R7", "width kept", fall_cyc - rise_cyc, P);
        chk(rise_cnt == n0 + 1, "R7", "no extra pulse", rise_cnt - n0, 1);

        // R8: long high sync level and falling edge
        load(100);
        idle(3);
        n0 = rise_cnt;
        sync_pulse(c0, 2000);
        idle(300);
        chk(rise_cnt == n0 + 1, "R8", "level held high", rise_cnt - n0, 1);

        // R9: sparse tick
        tick_div = 4;
        idle(8);
        load(20);
        idle(3);
        sync_pulse(c0, 10);
        idle(4 * 20 + 4 * P + 40);
        d = rise_cyc - c0;
        chk(d >= LAT + 1 + 4 * 19 && d <= LAT + 4 + 4 * 19, "R9", "delay in ticks", d, LAT + 4 * 20);
        chk(fall_cyc - rise_cyc == 4 * P, "R9", "width in ticks", fall_cyc - rise_cyc, 4 * P);
        tick_div = 1;
        idle(8);

        // R1: reset in the middle of a pulse
        load(30);
        idle(3);
        sync_pulse(c0, 10);
        idle(LAT + 30 + 20 - 10);
        chk(gate_out == 1'b1, "R4", "pulse in progress", gate_out, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(gate_out == 1'b0, "R1", "reset clears pulse", gate_out, 0);
        idle(3);
        rst = 1'b0;
        n0 = rise_cnt;
        idle(200);
        chk(rise_cnt == n0, "R1", "quiet after reset", rise_cnt - n0, 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule